// File: doc/BRIEF.md
# Serial bus link-PHY interface

This block is the link-layer end of the synchronous connection between a serial-bus controller and its physical-layer chip. Every signal is timed by the clock the PHY supplies, nominally about 49 MHz. The PHY owns the shared 2-bit control lines and 4-bit data lines by default. The code it places on the control lines selects the phase of each cycle: idle, status delivery, packet reception, or a grant that hands the lines to the link. The link starts only one kind of exchange itself. That is a request, which it shifts out serially on a dedicated one-wire line to the PHY.

The block turns status phases into 16-bit status words. It packs received packet data into 32-bit quadlets at either lane width and marks the end of each packet. When the PHY grants the lines, it takes them over and sends quadlets from a valid/ready source. Requests for bus access and for reading or writing PHY registers are framed and shifted out on the request line. The bidirectional lines are split into input, output and output-enable ports, so that a pad cell can resolve them. The receive logic reads the resolved pad value.

Top module: `plif_link`

## Requirements
- R1: While reset is held, ctl_oe, d_oe, lreq, stat_valid, rx_valid and rx_end are all 0, and req_ready is 1.
- R2: While the PHY drives control code 00 (idle), stat_valid, rx_valid and rx_end stay 0 and ctl_oe stays 0, whatever is on the data lines.
- R3: Control code 01 delivers a 16-bit status word 2 bits per cycle on d_in[1:0], most significant pair first. stat_valid pulses for one cycle, carrying the word, in the cycle after the eighth pair is sampled.
- R4: If the code leaves 01 before the eighth pair, stat_valid pulses once in the next cycle. The pairs received fill the word from the top, and the remaining bits are 0.
- R5: Under control code 10, leading data values of 1111 are ignored. The first other value is the speed code: 0100 selects the 4-bit lane mode, and any other value selects the 2-bit mode.
- R6: In 2-bit mode, d_in[1:0] is packed most significant pair first. After each 16th pair, rx_valid pulses for one cycle with the 32-bit quadlet on rx_data.
- R7: In 4-bit mode, d_in[3:0] is packed most significant nibble first, and rx_valid pulses after each 8th nibble.
- R8: When the code leaves 10 after a receive phase, rx_end pulses for one cycle, and a partly filled quadlet is dropped without an rx_valid.
- R9: Starting in the cycle after control code 11 is sampled, the link drives ctl_oe=1, ctl_out=01 and d_out=0. It keeps tx_ready high for as long as no quadlet is offered.
- R10: Each accepted quadlet is sent with ctl_out=10, most significant bits first. It goes out 2 bits per cycle on d_out[1:0], or 4 bits per cycle if tx_dbl was 1 when the grant was sampled. A following quadlet offered in the final beat is accepted in that beat and sent without a gap.
- R11: After the last beat of the quadlet marked by tx_last, the link drives ctl_out=00 for exactly one cycle and then releases both buses (ctl_oe=d_oe=0).
- R12: A request accepted by req_valid with req_ready shifts out on lreq starting in the next cycle. The frame is a 1 start bit, then the 3-bit type most significant bit first, then the payload, then a 0 stop bit. req_ready is 0 while the frame is in flight, and lreq is 0 whenever no frame is in flight.
- R13: The payload depends on the type. Type 001 (register read) carries a 4-bit address. Type 101 (register write) carries a 4-bit address and then 8 data bits. Every other type carries none, so frames are 9, 17 or 5 bits long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the PHY |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_in | input | 2 | Resolved control lines from the pad |
| ctl_out | output | 2 | Control value driven by the link |
| ctl_oe | output | 1 | Link drives the control lines |
| d_in | input | 4 | Resolved data lines from the pad |
| d_out | output | 4 | Data value driven by the link |
| d_oe | output | 1 | Link drives the data lines |
| lreq | output | 1 | Serial request line to the PHY |
| stat_valid | output | 1 | One-cycle status word strobe |
| stat_word | output | 16 | Assembled status word |
| rx_valid | output | 1 | One-cycle received quadlet strobe |
| rx_data | output | 32 | Received quadlet |
| rx_end | output | 1 | One-cycle end-of-packet strobe |
| tx_dbl | input | 1 | Use 4-bit lanes for the next grant |
| tx_valid | input | 1 | Transmit quadlet offered |
| tx_ready | output | 1 | Transmit quadlet taken this cycle |
| tx_data | input | 32 | Transmit quadlet |
| tx_last | input | 1 | Offered quadlet ends the packet |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request serializer is free |
| req_type | input | 3 | Request type code |
| req_addr | input | 4 | PHY register address |
| req_wdata | input | 8 | PHY register write data |

## Verification
The bench builds the block with its default parameters: 32-bit quadlets, 16-bit status words, and request fields of 3, 4 and 8 bits. With these values every frame length the serializer can produce (5, 9 and 17 bits) is reachable. So are complete and truncated status words, and both the 16-beat and the 8-beat quadlet cadence in each direction. Partial quadlets at the end of a packet can be reached at both lane widths, and so can a grant that arrives before any data is offered.

// File: rtl/plif_pkg.sv
// Package: control codes and request types shared by the link-PHY interface.
// Assumes the 2-bit control lines and the 4-bit data lines of the interface.
package plif_pkg;
    // Codes the PHY places on the control lines
    localparam logic [1:0] PHY_IDLE    = 2'b00;
    localparam logic [1:0] PHY_STATUS  = 2'b01;
    localparam logic [1:0] PHY_RECEIVE = 2'b10;
    localparam logic [1:0] PHY_GRANT   = 2'b11;
    // Codes the link places on the control lines once granted
    localparam logic [1:0] LNK_HOLD    = 2'b01;
    localparam logic [1:0] LNK_XMIT    = 2'b10;
    localparam logic [1:0] LNK_DONE    = 2'b00;
    // Receive data markers
    localparam logic [3:0] DATA_ON     = 4'b1111;
    localparam logic [3:0] SPD_DOUBLE  = 4'b0100;
    // Request types that carry payload
    localparam logic [2:0] RQ_REG_READ  = 3'b001;
    localparam logic [2:0] RQ_REG_WRITE = 3'b101;

    typedef enum logic [1:0] {TX_IDLE, TX_HOLD, TX_SEND, TX_DONE} tx_state_t;
endpackage

// File: rtl/plif_status_rx.sv
// Status assembler: collects bit pairs from d[1:0] while the PHY shows the
// status code and emits a word when it is full or when the phase ends early.
// Assumes listen is low whenever the link itself owns the control lines.
module plif_status_rx
    import plif_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              listen,
    input  logic [1:0]        ctl_in,
    input  logic [1:0]        d_pair,
    output logic              stat_valid,
    output logic [STAT_W-1:0] stat_word
);
    localparam int NPAIR = STAT_W / 2;
    localparam int CW    = $clog2(NPAIR + 1);

    logic              active;
    logic [CW-1:0]     pairs;
    logic [STAT_W-1:0] acc;
    logic              is_stat;
    logic [CW-1:0]     pairs_eff;
    logic [CW-1:0]     pairs_nx;
    logic [STAT_W-1:0] merged;

    // Place the incoming pair below those already collected
    always_comb begin
        is_stat   = listen && (ctl_in == PHY_STATUS);
        pairs_eff = active ? pairs : '0;
        pairs_nx  = pairs_eff + 1'b1;
        merged    = (active ? acc : '0)
                  | ({d_pair, {(STAT_W-2){1'b0}}} >> {pairs_eff, 1'b0});
    end

    // Track the status phase and strobe the finished word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            pairs      <= '0;
            acc        <= '0;
            stat_valid <= 1'b0;
            stat_word  <= '0;
        end else begin
            stat_valid <= 1'b0;
            if (is_stat) begin
                if (!active || pairs != CW'(NPAIR)) begin
                    active <= 1'b1;
                    acc    <= merged;
                    pairs  <= pairs_nx;
                    if (pairs_nx == CW'(NPAIR)) begin
                        stat_valid <= 1'b1;
                        stat_word  <= merged;
                    end
                end
            end else if (active) begin
                active <= 1'b0;
                pairs  <= '0;
                if (pairs != CW'(NPAIR)) begin
                    stat_valid <= 1'b1;
                    stat_word  <= acc;
                end
            end
        end
    end

    // A word is announced in one cycle only
    assert_stat_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);
    // Idle code never produces a status word
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && ctl_in == PHY_IDLE) |=> !stat_valid);
endmodule

// File: rtl/plif_pkt_rx.sv
// Packet receiver: skips the data-on pattern, takes the speed code, then packs
// 2- or 4-bit beats into quadlets and strobes the end of each packet.
// Assumes listen is low whenever the link itself owns the control lines.
module plif_pkt_rx
    import plif_pkg::*;
#(
    parameter int QUAD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              listen,
    input  logic [1:0]        ctl_in,
    input  logic [3:0]        d_in,
    output logic              q_valid,
    output logic [QUAD_W-1:0] q_data,
    output logic              pkt_end
);
    localparam int BW = $clog2(QUAD_W + 1);

    logic              in_pkt;
    logic              spd_seen;
    logic              dbl;
    logic [QUAD_W-1:0] sr;
    logic [BW-1:0]     bits;
    logic              is_rx;
    logic [QUAD_W-1:0] sr_nx;
    logic [BW-1:0]     bits_nx;

    // Next shift value and bit count for the current lane width
    always_comb begin
        is_rx   = listen && (ctl_in == PHY_RECEIVE);
        sr_nx   = dbl ? {sr[QUAD_W-5:0], d_in} : {sr[QUAD_W-3:0], d_in[1:0]};
        bits_nx = bits + (dbl ? BW'(4) : BW'(2));
    end

    // Receive phase tracking, speed detection and quadlet packing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt   <= 1'b0;
            spd_seen <= 1'b0;
            dbl      <= 1'b0;
            sr       <= '0;
            bits     <= '0;
            q_valid  <= 1'b0;
            q_data   <= '0;
            pkt_end  <= 1'b0;
        end else begin
            q_valid <= 1'b0;
            pkt_end <= 1'b0;
            if (is_rx) begin
                in_pkt <= 1'b1;
                if (!spd_seen) begin
                    if (d_in != DATA_ON) begin
                        spd_seen <= 1'b1;
                        dbl      <= (d_in == SPD_DOUBLE);
                        bits     <= '0;
                    end
                end else begin
                    sr <= sr_nx;
                    if (bits_nx == BW'(QUAD_W)) begin
                        q_valid <= 1'b1;
                        q_data  <= sr_nx;
                        bits    <= '0;
                    end else begin
                        bits <= bits_nx;
                    end
                end
            end else if (in_pkt) begin
                in_pkt   <= 1'b0;
                spd_seen <= 1'b0;
                bits     <= '0;
                pkt_end  <= 1'b1;
            end
        end
    end

    // Data-on beats before the speed code never complete a quadlet
    assert_dataon_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rx && !spd_seen && d_in == DATA_ON) |=> !q_valid);
    // Quadlet strobes are single-cycle
    assert_quad_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> !q_valid);
    // End-of-packet strobe is single-cycle
    assert_end_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end);
endmodule

// File: rtl/plif_tx.sv
// Transmit sequencer: on a grant takes the control and data lines, holds
// until a quadlet is offered, shifts quadlets out, closes with one done cycle
// and releases. Assumes the PHY stops driving after the grant cycle.
module plif_tx
    import plif_pkg::*;
#(
    parameter int QUAD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ctl_in,
    input  logic              tx_dbl,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [QUAD_W-1:0] tx_data,
    input  logic              tx_last,
    output logic [1:0]        ctl_out,
    output logic              ctl_oe,
    output logic [3:0]        d_out,
    output logic              d_oe
);
    localparam int BEAT_LO = QUAD_W / 2;
    localparam int BEAT_HI = QUAD_W / 4;
    localparam int BW      = $clog2(BEAT_LO + 1);

    tx_state_t         state;
    logic              dbl;
    logic              last_q;
    logic [QUAD_W-1:0] sr;
    logic [BW-1:0]     beat;
    logic              final_beat;

    // Handshake and beat position
    always_comb begin
        final_beat = (beat == (dbl ? BW'(BEAT_HI - 1) : BW'(BEAT_LO - 1)));
        tx_ready   = (state == TX_HOLD) || (state == TX_SEND && final_beat && !last_q);
    end

    // Bus drive values for each state
    always_comb begin
        ctl_out = LNK_DONE;
        d_out   = 4'b0000;
        ctl_oe  = 1'b1;
        d_oe    = 1'b1;
        case (state)
            TX_IDLE: begin
                ctl_oe = 1'b0;
                d_oe   = 1'b0;
            end
            TX_HOLD: ctl_out = LNK_HOLD;
            TX_SEND: begin
                ctl_out = LNK_XMIT;
                d_out   = dbl ? sr[QUAD_W-1 -: 4] : {2'b00, sr[QUAD_W-1 -: 2]};
            end
            default: ctl_out = LNK_DONE;
        endcase
    end

    // Grant detection, quadlet loading and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TX_IDLE;
            dbl    <= 1'b0;
            last_q <= 1'b0;
            sr     <= '0;
            beat   <= '0;
        end else begin
            case (state)
                TX_IDLE: if (ctl_in == PHY_GRANT) begin
                    state <= TX_HOLD;
                    dbl   <= tx_dbl;
                end
                TX_HOLD: if (tx_valid) begin
                    sr     <= tx_data;
                    last_q <= tx_last;
                    beat   <= '0;
                    state  <= TX_SEND;
                end
                TX_SEND: if (final_beat) begin
                    if (last_q) begin
                        state <= TX_DONE;
                    end else if (tx_valid) begin
                        sr     <= tx_data;
                        last_q <= tx_last;
                        beat   <= '0;
                    end else begin
                        state <= TX_HOLD;
                    end
                end else begin
                    sr   <= dbl ? (sr << 4) : (sr << 2);
                    beat <= beat + 1'b1;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // The link only takes the lines after the PHY showed a grant
    assert_take_after_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_oe) |-> $past(ctl_in) == PHY_GRANT);
    // The done cycle is followed by release
    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && ctl_out == LNK_DONE) |=> (!ctl_oe && !d_oe));
endmodule

// File: rtl/plif_req.sv
// Request serializer: frames a request as start bit, type, type-dependent
// payload and stop bit, and shifts it out on the request line.
// Assumes one request at a time; the line rests low between frames.
module plif_req
    import plif_pkg::*;
#(
    parameter int RT_W   = 3,
    parameter int ADDR_W = 4,
    parameter int WDAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [RT_W-1:0]   req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WDAT_W-1:0] req_wdata,
    output logic              lreq
);
    localparam int FW = RT_W + ADDR_W + WDAT_W + 2;
    localparam int LW = $clog2(FW + 1);

    logic          busy;
    logic [FW-1:0] sr;
    logic [LW-1:0] left;
    logic [FW-1:0] frame;
    logic [LW-1:0] flen;

    // Build the left-aligned frame and its length from the request type
    always_comb begin
        frame          = '0;
        frame[FW-1]    = 1'b1;
        frame[FW-2 -: RT_W] = req_type;
        flen           = LW'(RT_W + 2);
        if (req_type == RT_W'(RQ_REG_READ)) begin
            frame[FW-2-RT_W -: ADDR_W] = req_addr;
            flen = LW'(RT_W + ADDR_W + 2);
        end else if (req_type == RT_W'(RQ_REG_WRITE)) begin
            frame[FW-2-RT_W -: ADDR_W]        = req_addr;
            frame[FW-2-RT_W-ADDR_W -: WDAT_W] = req_wdata;
            flen = LW'(FW);
        end
        req_ready = !busy;
        lreq      = busy && sr[FW-1];
    end

    // Load a frame and shift it out one bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sr   <= '0;
            left <= '0;
        end else if (!busy) begin
            if (req_valid) begin
                busy <= 1'b1;
                sr   <= frame;
                left <= flen;
            end
        end else begin
            sr   <= sr << 1;
            left <= left - 1'b1;
            if (left == LW'(1)) busy <= 1'b0;
        end
    end

    // The cycle after acceptance carries the start bit
    assert_start_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> lreq);
    // The final bit of every frame is the stop bit
    assert_stop_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && left == LW'(1)) |-> !lreq);
endmodule

// File: rtl/plif_link.sv
// Link-side interface top: splits the shared lines into pad-side in/out/enable
// ports, gates the receivers while the link owns the lines, and joins the
// status, packet, transmit and request parts. Assumes the pad feeds the
// resolved line value back on ctl_in/d_in.
module plif_link
    import plif_pkg::*;
#(
    parameter int QUAD_W = 32,
    parameter int STAT_W = 16,
    parameter int RT_W   = 3,
    parameter int ADDR_W = 4,
    parameter int WDAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ctl_in,
    output logic [1:0]        ctl_out,
    output logic              ctl_oe,
    input  logic [3:0]        d_in,
    output logic [3:0]        d_out,
    output logic              d_oe,
    output logic              lreq,
    output logic              stat_valid,
    output logic [STAT_W-1:0] stat_word,
    output logic              rx_valid,
    output logic [QUAD_W-1:0] rx_data,
    output logic              rx_end,
    input  logic              tx_dbl,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [QUAD_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [RT_W-1:0]   req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WDAT_W-1:0] req_wdata
);
    logic listen;

    // Receivers only listen while the PHY owns the lines
    always_comb listen = !ctl_oe;

    plif_status_rx #(.STAT_W(STAT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .listen(listen), .ctl_in(ctl_in),
        .d_pair(d_in[1:0]), .stat_valid(stat_valid), .stat_word(stat_word)
    );

    plif_pkt_rx #(.QUAD_W(QUAD_W)) u_pkt_rx (
        .clk(clk), .rst_n(rst_n), .listen(listen), .ctl_in(ctl_in),
        .d_in(d_in), .q_valid(rx_valid), .q_data(rx_data), .pkt_end(rx_end)
    );

    plif_tx #(.QUAD_W(QUAD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .tx_dbl(tx_dbl),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .ctl_out(ctl_out), .ctl_oe(ctl_oe),
        .d_out(d_out), .d_oe(d_oe)
    );

    plif_req #(.RT_W(RT_W), .ADDR_W(ADDR_W), .WDAT_W(WDAT_W)) u_req (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
        .lreq(lreq)
    );
endmodule

// File: tb/plif_link_tb.sv
// Scoreboard bench: drivers push expected status words, quadlets and
// transmit words into queues; a negedge monitor pops and compares them.
module plif_link_tb;
    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  phy_ctl = 2'b00;
    logic [3:0]  phy_d = 4'b0000;
    logic [1:0]  ctl_in, ctl_out;
    logic        ctl_oe, d_oe;
    logic [3:0]  d_in, d_out;
    logic        lreq, stat_valid, rx_valid, rx_end, tx_ready, req_ready;
    logic [15:0] stat_word;
    logic [31:0] rx_data;
    logic        tx_dbl = 1'b0, tx_valid = 1'b0, tx_last = 1'b0, req_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic [2:0]  req_type = '0;
    logic [3:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;

    int n_checks = 0;
    int n_fail = 0;
    int rx_end_cnt = 0;
    bit done = 0;
    bit mon_dbl = 0;
    logic [31:0] tx_acc = '0;
    int tx_nb = 0;
    logic [15:0] exp_st[$];
    logic [31:0] exp_rx[$];
    logic [31:0] exp_tx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pad model: the link wins when it enables its drivers
    assign ctl_in = ctl_oe ? ctl_out : phy_ctl;
    assign d_in   = d_oe ? d_out : phy_d;

    plif_link u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .ctl_out(ctl_out),
        .ctl_oe(ctl_oe), .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .lreq(lreq),
        .stat_valid(stat_valid), .stat_word(stat_word), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .tx_dbl(tx_dbl), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata)
    );

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Monitor: compare every strobe against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (stat_valid) begin
                if (exp_st.size() == 0) check(0, "R3 unexpected status word", {16'h0, stat_word}, 32'h0);
                else begin
                    logic [15:0] e;
                    e = exp_st.pop_front();
                    check(stat_word == e, "R3/R4 status word", {16'h0, stat_word}, {16'h0, e});
                end
            end
            if (rx_valid) begin
                if (exp_rx.size() == 0) check(0, "R6 unexpected quadlet", rx_data, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_rx.pop_front();
                    check(rx_data == e, "R6/R7 received quadlet", rx_data, e);
                end
            end
            if (rx_end) rx_end_cnt++;
            if (ctl_oe && ctl_out == 2'b10) begin
                tx_acc = mon_dbl ? {tx_acc[27:0], d_out} : {tx_acc[29:0], d_out[1:0]};
                tx_nb  = tx_nb + (mon_dbl ? 4 : 2);
                if (tx_nb == 32) begin
                    tx_nb = 0;
                    if (exp_tx.size() == 0) check(0, "R10 unexpected transmit word", tx_acc, 32'h0);
                    else begin
                        logic [31:0] e;
                        e = exp_tx.pop_front();
                        check(tx_acc == e, "R10 transmitted word", tx_acc, e);
                    end
                end
            end
        end
    end

    task automatic phy_status(input logic [15:0] w, input int npairs);
        for (int i = 0; i < npairs; i++) begin
            phy_ctl = 2'b01;
            phy_d   = {2'b00, 2'((w >> (14 - 2*i)) & 16'h3)};
            @(negedge clk);
        end
        phy_ctl = 2'b00;
        phy_d   = 4'b0000;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic phy_recv(input logic [3:0] spd, input bit dbl,
                            input logic [31:0] w0, input logic [31:0] w1,
                            input int nw, input int extra);
        int beats;
        beats = dbl ? 8 : 16;
        phy_ctl = 2'b10;
        phy_d   = 4'b1111;
        @(negedge clk);
        @(negedge clk);
        phy_d = spd;
        @(negedge clk);
        for (int k = 0; k < nw * beats + extra; k++) begin
            logic [31:0] w;
            int b;
            w = (k / beats == 0) ? w0 : w1;
            b = k % beats;
            if (k >= nw * beats) w = 32'hFFFF_FFFF;
            phy_d = dbl ? 4'((w >> (28 - 4*b)) & 32'hF) : {2'b00, 2'((w >> (30 - 2*b)) & 32'h3)};
            @(negedge clk);
        end
        phy_ctl = 2'b00;
        phy_d   = 4'b0000;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic grant();
        phy_ctl = 2'b11;
        @(negedge clk);
        phy_ctl = 2'b00;
        check(ctl_oe && d_oe && ctl_out == 2'b01 && d_out == 4'h0, "R9 hold after grant",
              {28'h0, ctl_oe, d_oe, ctl_out}, 32'h0000_000D);
    endtask

    task automatic tx_send(input logic [31:0] w, input bit last);
        tx_valid = 1'b1;
        tx_data  = w;
        tx_last  = last;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic expect_close();
        bit seen;
        seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (ctl_oe && ctl_out == 2'b00) seen = 1;
            else @(negedge clk);
        end
        check(seen, "R11 done cycle with ctl 00", {31'h0, seen}, 32'h1);
        @(negedge clk);
        check(!ctl_oe && !d_oe, "R11 buses released", {30'h0, ctl_oe, d_oe}, 32'h0);
    endtask

    task automatic send_req(input logic [2:0] t, input logic [3:0] a, input logic [7:0] wd);
        logic [16:0] fr;
        int n;
        if (t == 3'b001) begin fr = {1'b1, t, a, 1'b0, 8'h00}; n = 9; end
        else if (t == 3'b101) begin fr = {1'b1, t, a, wd, 1'b0}; n = 17; end
        else begin fr = {1'b1, t, 1'b0, 12'h000}; n = 5; end
        check(req_ready && !lreq, "R12 idle before request", {30'h0, req_ready, lreq}, 32'h2);
        req_valid = 1'b1;
        req_type  = t;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R12 ready low in flight", {31'h0, req_ready}, 32'h0);
        for (int k = 0; k < n; k++) begin
            check(lreq == fr[16-k], "R13 request frame bit", {31'h0, lreq}, {31'h0, fr[16-k]});
            @(negedge clk);
        end
        check(!lreq && req_ready, "R12 line low and ready after stop", {30'h0, req_ready, lreq}, 32'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL all watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!ctl_oe && !d_oe && !lreq && !stat_valid && !rx_valid && !rx_end && req_ready,
              "R1 reset outputs", {25'h0, ctl_oe, d_oe, lreq, stat_valid, rx_valid, rx_end, req_ready},
              32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: idle code with toggling data does nothing
        for (int i = 0; i < 6; i++) begin
            phy_ctl = 2'b00;
            phy_d   = 4'(i * 5);
            @(negedge clk);
            check(!stat_valid && !rx_valid && !rx_end && !ctl_oe, "R2 idle quiet",
                  {28'h0, stat_valid, rx_valid, rx_end, ctl_oe}, 32'h0);
        end

        // R3: full status word
        exp_st.push_back(16'hA5C3);
        phy_status(16'hA5C3, 8);
        // R4: truncated after three pairs
        exp_st.push_back(16'hDB5A & ~(16'hFFFF >> 6));
        phy_status(16'hDB5A, 3);
        check(exp_st.size() == 0, "R4 all status words seen", exp_st.size(), 32'h0);

        // R5/R6/R8: low speed, two quadlets and a dropped partial
        e0 = rx_end_cnt;
        exp_rx.push_back(32'hA1B2_C3D4);
        exp_rx.push_back(32'h5E6F_7081);
        phy_recv(4'b0000, 0, 32'hA1B2_C3D4, 32'h5E6F_7081, 2, 3);
        check(exp_rx.size() == 0, "R6 low speed quadlets", exp_rx.size(), 32'h0);
        check(rx_end_cnt == e0 + 1, "R8 one end strobe", rx_end_cnt, e0 + 1);

        // R7: double speed with partial tail
        exp_rx.push_back(32'h1234_5678);
        phy_recv(4'b0100, 1, 32'h1234_5678, 32'h0, 1, 2);
        check(exp_rx.size() == 0, "R7 double speed quadlet", exp_rx.size(), 32'h0);
        check(rx_end_cnt == e0 + 2, "R8 end strobe after double", rx_end_cnt, e0 + 2);

        // R5: non-double speed code falls back to 2-bit lanes
        exp_rx.push_back(32'hCAFE_F00D);
        phy_recv(4'b0001, 0, 32'hCAFE_F00D, 32'h0, 1, 0);
        check(exp_rx.size() == 0, "R5 other speed code is low", exp_rx.size(), 32'h0);

        // R9/R10/R11: low speed transmit, two quadlets back to back
        tx_dbl  = 1'b0;
        mon_dbl = 0;
        exp_tx.push_back(32'hDEAD_BEEF);
        exp_tx.push_back(32'h0F0F_1234);
        fork
            grant();
            begin
                tx_send(32'hDEAD_BEEF, 0);
                tx_send(32'h0F0F_1234, 1);
            end
        join
        expect_close();
        check(exp_tx.size() == 0, "R10 low speed words sent", exp_tx.size(), 32'h0);

        // R9: grant before data holds the lines; then double-speed word
        tx_dbl  = 1'b1;
        mon_dbl = 1;
        grant();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(ctl_oe && ctl_out == 2'b01 && tx_ready, "R9 hold while idle source",
                  {29'h0, ctl_oe, ctl_out[0], tx_ready}, 32'h7);
        end
        exp_tx.push_back(32'h1357_9BDF);
        tx_send(32'h1357_9BDF, 1);
        expect_close();
        check(exp_tx.size() == 0, "R10 double speed word sent", exp_tx.size(), 32'h0);
        tx_dbl = 1'b0;

        // R12/R13: request frames of every length
        send_req(3'b001, 4'hA, 8'h00);
        send_req(3'b101, 4'h3, 8'hC6);
        send_req(3'b010, 4'hF, 8'hFF);

        repeat (4) @(negedge clk);
        check(exp_st.size() == 0 && exp_rx.size() == 0 && exp_tx.size() == 0,
              "R2 scoreboard drained", exp_st.size() + exp_rx.size() + exp_tx.size(), 32'h0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule